// File: doc/BRIEF.md
# Receive Frame Buffer with Commit and Rollback

This block sits between a receive frame parser and a protocol decoder. The parser streams payload words into it while a frame arrives. At the end of the frame it gives a verdict. Words from a frame judged good become visible to the reader together. Words from a frame judged bad vanish, as though they had never been written. The buffer holds payload only; headers never reach it.

For every frame it keeps, the block queues a descriptor that carries the word count and the 48-bit sender address. The decoder takes a descriptor and then reads exactly that number of payload words. Only then does the next descriptor appear.

If either the payload store or the descriptor queue runs out of room while a frame is in progress, the whole frame is discarded. A saturating counter then records the loss.

Top module: `rx_frame_buffer`

## Requirements
- R1: After reset, `buf_empty` is 1, `buf_count` is 0, `desc_valid` and `pl_valid` are 0, and `ovf_count` is 0.
- R2: A frame whose `in_end` strobe has `in_good`=1 is committed. The next cycle, `buf_count` grows by its word count. A descriptor then shows `desc_len` equal to that count and `desc_src` equal to the `in_src` given with the strobe. Its words come out on `pl_data` in the order they were written.
- R3: A frame whose `in_end` strobe has `in_good`=0 leaves `buf_count`, the descriptors and the payload stream exactly as they were before the frame.
- R4: While a frame is being written, `buf_count` and `buf_empty` do not change because of its words. A rise in `buf_count` happens only in the cycle after a commit.
- R5: A word presented with `in_valid`=1 in the same cycle as `in_end` belongs to the frame that ends there. A strobe in a cycle of its own adds no word.
- R6: A frame with more words than the free payload space is dropped whatever its verdict, and `ovf_count` increments once. A frame that exactly fills the free space is kept. Frames already committed are unaffected.
- R7: A good, non-empty frame that ends while `DESC_DEPTH` descriptors are waiting is dropped, and `ovf_count` increments once.
- R8: While a frame's words remain to be read, `desc_valid` is 0 and `desc_pop` is ignored. `pl_valid` is 1 only between a pop and the last word of that frame. `pl_rd` with `pl_valid`=0 changes nothing.
- R9: A good frame of zero words creates no descriptor and does not change `ovf_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Payload word present on `in_data` |
| in_data | input | DW | Payload word from the parser |
| in_end | input | 1 | End-of-frame verdict strobe |
| in_good | input | 1 | Verdict with `in_end`: 1 keep, 0 discard |
| in_src | input | 48 | Sender address, sampled with `in_end` |
| desc_valid | output | 1 | A descriptor may be taken |
| desc_len | output | log2(DEPTH)+1 | Word count of the head frame |
| desc_src | output | 48 | Sender address of the head frame |
| desc_pop | input | 1 | Take the head descriptor |
| pl_valid | output | 1 | A word of the current frame is on `pl_data` |
| pl_data | output | DW | Payload word being read |
| pl_rd | input | 1 | Consume the word on `pl_data` |
| buf_empty | output | 1 | No committed unread words |
| buf_count | output | log2(DEPTH)+1 | Committed unread words |
| ovf_count | output | OVF_W | Saturating count of frames lost to full storage |

## Verification
The assertions assume that the parser never raises `in_end` while reset is held. They also assume that commit and rollback are never requested together, and that the reader pops only descriptors with non-zero lengths; the block itself guarantees the last point. The bench keeps writes and reads in separate phases, and in the directed tests it follows each frame with a verdict. Because of this, the bench model's free-space and descriptor counts match the block's at every verdict. The random frame lengths sometimes exceed the whole store and sometimes hit the descriptor limit, so both overflow paths are exercised without leaving the legal input space.

// File: rtl/rxfb_pkg.sv
package rxfb_pkg;
  localparam int unsigned SRC_W = 48;
  typedef logic [SRC_W-1:0] src_addr_t;
endpackage

// File: rtl/rxfb_rst_sync.sv
module rxfb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= 2'b00;
    else        sr_q <= {sr_q[0], 1'b1};
  end

  assign rst_sync_n = sr_q[1];
endmodule

// File: rtl/rxfb_data_store.sv
module rxfb_data_store #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [DW-1:0]              wr_data,
  input  logic                       commit,
  input  logic                       rollback,
  input  logic                       rd_en,
  output logic [DW-1:0]              rd_data,
  output logic                       tent_full,
  output logic [$clog2(DEPTH):0]     frame_len,
  output logic [$clog2(DEPTH):0]     comm_count
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp_t_q, wp_t_d;
  logic [PW-1:0] wp_c_q, wp_c_d;
  logic [PW-1:0] rp_q, rp_d;
  logic [PW-1:0] wr_inc;

  assign wr_inc = {{AW{1'b0}}, wr_en};

  always_comb begin
    wp_t_d = wp_t_q + wr_inc;
    if (rollback) wp_t_d = wp_c_q;
    wp_c_d = commit ? (wp_t_q + wr_inc) : wp_c_q;
    rp_d   = rp_q + {{AW{1'b0}}, rd_en};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_t_q <= '0;
      wp_c_q <= '0;
      rp_q   <= '0;
    end else begin
      wp_t_q <= wp_t_d;
      wp_c_q <= wp_c_d;
      rp_q   <= rp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp_t_q[AW-1:0]] <= wr_data;
  end

  assign rd_data    = mem[rp_q[AW-1:0]];
  assign tent_full  = (wp_t_q - rp_q) == PW'(DEPTH);
  assign frame_len  = (wp_t_q - wp_c_q) + wr_inc;
  assign comm_count = wp_c_q - rp_q;

  // R3
  rollback_keeps_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rollback |=> (wp_c_q == $past(wp_c_q)));

  // R6
  no_write_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !tent_full);

  // R2
  commit_rollback_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && rollback));
endmodule

// File: rtl/rxfb_desc_queue.sv
module rxfb_desc_queue #(
  parameter int unsigned W     = 55,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slot [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) begin
      wr_d  = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      cnt_d = cnt_d + 1'b1;
    end
    if (pop) begin
      rd_d  = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      cnt_d = cnt_d - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) slot[wr_q] <= push_data;
  end

  assign head  = slot[rd_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));

  // R7
  no_push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R8
  no_pop_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/rxfb_read_ctrl.sv
module rxfb_read_ctrl #(
  parameter int unsigned PW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          desc_avail,
  input  logic [PW-1:0] head_len,
  input  logic          desc_pop,
  input  logic          pl_rd,
  output logic          desc_valid,
  output logic          pop_q,
  output logic          pl_valid,
  output logic          rd_adv
);
  logic [PW-1:0] remain_q, remain_d;

  assign desc_valid = desc_avail && (remain_q == '0);
  assign pop_q      = desc_pop && desc_valid;
  assign pl_valid   = (remain_q != '0);
  assign rd_adv     = pl_rd && pl_valid;

  always_comb begin
    remain_d = remain_q;
    if (pop_q)       remain_d = head_len;
    else if (rd_adv) remain_d = remain_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) remain_q <= '0;
    else        remain_q <= remain_d;
  end

  // R8
  pop_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_q |=> pl_valid);

  // R8
  drain_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pl_valid) |-> $past(rd_adv));
endmodule

// File: rtl/rx_frame_buffer.sv
module rx_frame_buffer
  import rxfb_pkg::*;
#(
  parameter int unsigned DW         = 16,
  parameter int unsigned DEPTH      = 64,
  parameter int unsigned DESC_DEPTH = 4,
  parameter int unsigned OVF_W      = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [DW-1:0]          in_data,
  input  logic                   in_end,
  input  logic                   in_good,
  input  logic [SRC_W-1:0]       in_src,
  output logic                   desc_valid,
  output logic [$clog2(DEPTH):0] desc_len,
  output logic [SRC_W-1:0]       desc_src,
  input  logic                   desc_pop,
  output logic                   pl_valid,
  output logic [DW-1:0]          pl_data,
  input  logic                   pl_rd,
  output logic                   buf_empty,
  output logic [$clog2(DEPTH):0] buf_count,
  output logic [OVF_W-1:0]       ovf_count
);
  localparam int unsigned PW  = $clog2(DEPTH) + 1;
  localparam int unsigned DQW = PW + SRC_W;

  logic           rst_sync_n;
  logic           tent_full, wr_en, commit, rollback;
  logic           drop_now, want_keep, ovf_hit;
  logic [PW-1:0]  frame_len;
  logic           dq_empty, dq_full, pop_q, rd_adv;
  logic [DQW-1:0] dq_head;
  logic           frame_drop_q, frame_drop_d;
  logic [OVF_W-1:0] ovf_q, ovf_d;

  rxfb_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign wr_en     = in_valid && !frame_drop_q && !tent_full;
  assign drop_now  = frame_drop_q || (in_valid && tent_full);
  assign want_keep = in_end && in_good && !drop_now && (frame_len != '0);
  assign commit    = want_keep && !dq_full;
  assign rollback  = in_end && !commit;
  assign ovf_hit   = in_end && (drop_now || (want_keep && dq_full));

  always_comb begin
    frame_drop_d = in_end ? 1'b0 : drop_now;
    ovf_d        = (ovf_hit && !(&ovf_q)) ? ovf_q + 1'b1 : ovf_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      frame_drop_q <= 1'b0;
      ovf_q        <= '0;
    end else begin
      frame_drop_q <= frame_drop_d;
      ovf_q        <= ovf_d;
    end
  end

  rxfb_data_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(wr_en), .wr_data(in_data),
    .commit(commit), .rollback(rollback),
    .rd_en(rd_adv), .rd_data(pl_data),
    .tent_full(tent_full), .frame_len(frame_len), .comm_count(buf_count)
  );

  rxfb_desc_queue #(.W(DQW), .DEPTH(DESC_DEPTH)) u_desc (
    .clk(clk), .rst_n(rst_sync_n),
    .push(commit), .push_data({frame_len, in_src}),
    .pop(pop_q), .head(dq_head), .empty(dq_empty), .full(dq_full)
  );

  rxfb_read_ctrl #(.PW(PW)) u_rd (
    .clk(clk), .rst_n(rst_sync_n),
    .desc_avail(!dq_empty), .head_len(dq_head[DQW-1:SRC_W]),
    .desc_pop(desc_pop), .pl_rd(pl_rd),
    .desc_valid(desc_valid), .pop_q(pop_q), .pl_valid(pl_valid), .rd_adv(rd_adv)
  );

  assign desc_len  = dq_head[DQW-1:SRC_W];
  assign desc_src  = dq_head[SRC_W-1:0];
  assign buf_empty = (buf_count == '0);
  assign ovf_count = ovf_q;

  // R2
  desc_cover_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    desc_valid |-> (buf_count >= desc_len));

  // R4
  count_rise_on_commit_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (buf_count > $past(buf_count)) |-> $past(commit));

  // R6
  ovf_on_verdict_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ovf_count != $past(ovf_count)) |-> $past(in_end));

  // R8
  payload_backed_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pl_valid |-> !buf_empty);
endmodule

// File: tb/tb_rx_frame_buffer.sv
`timescale 1ns/1ps
module tb_rx_frame_buffer;
  localparam int DW = 16;
  localparam int DEPTH = 64;
  localparam int DESC_DEPTH = 4;
  localparam int PW = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_end, in_good, desc_pop, pl_rd;
  logic [DW-1:0] in_data;
  logic [47:0] in_src;
  logic desc_valid, pl_valid, buf_empty;
  logic [PW-1:0] desc_len, buf_count;
  logic [47:0] desc_src;
  logic [DW-1:0] pl_data;
  logic [7:0] ovf_count;

  always #2 clk = ~clk;

  rx_frame_buffer dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_end(in_end), .in_good(in_good), .in_src(in_src),
    .desc_valid(desc_valid), .desc_len(desc_len), .desc_src(desc_src), .desc_pop(desc_pop),
    .pl_valid(pl_valid), .pl_data(pl_data), .pl_rd(pl_rd),
    .buf_empty(buf_empty), .buf_count(buf_count), .ovf_count(ovf_count)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int occ = 0;
  int mdesc = 0;
  int movf = 0;
  logic [DW-1:0] exp_words[$];
  int exp_len[$];
  logic [47:0] exp_src[$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // 0 = silent discard, 1 = kept, 2 = dropped with overflow count
  function automatic int verdict(int n, bit good, int cur_occ, int cur_desc);
    if (n > DEPTH - cur_occ) return 2;
    if (!good || n == 0) return 0;
    if (cur_desc >= DESC_DEPTH) return 2;
    return 1;
  endfunction

  task automatic send_frame(int n, bit good, bit end_on_last, logic [47:0] src);
    logic [DW-1:0] w[$];
    int v;
    int start_cnt;
    v = verdict(n, good, occ, mdesc);
    start_cnt = occ;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == n / 2 && n >= 2)
        chk(buf_count == PW'(start_cnt), "R4 mid-frame count", buf_count, start_cnt);
      w.push_back(DW'($urandom));
      in_valid = 1'b1;
      in_data  = w[i];
      in_end   = end_on_last && (i == n - 1);
      in_good  = good;
      in_src   = src;
    end
    if (!end_on_last || n == 0) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_end   = 1'b1;
      in_good  = good;
      in_src   = src;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_end   = 1'b0;
    if (v == 1) begin
      foreach (w[k]) exp_words.push_back(w[k]);
      exp_len.push_back(n);
      exp_src.push_back(src);
      occ += n;
      mdesc++;
    end else if (v == 2) begin
      if (movf < 255) movf++;
    end
    chk(buf_count == PW'(occ), good ? "R2/R6 count after verdict" : "R3 count after bad verdict", buf_count, occ);
    chk(ovf_count == 8'(movf), "R6/R7/R9 overflow count", ovf_count, movf);
    chk(desc_valid == (mdesc > 0), "R3/R9 descriptor presence", desc_valid, mdesc > 0);
  endtask

  task automatic drain_one();
    int n;
    logic [47:0] s;
    n = exp_len.pop_front();
    s = exp_src.pop_front();
    chk(desc_valid == 1'b1, "R2 descriptor valid", desc_valid, 1);
    chk(desc_len == PW'(n), "R2 descriptor length", desc_len, n);
    chk(desc_src == s, "R2 descriptor source", desc_src, s);
    chk(pl_valid == 1'b0, "R8 no payload before pop", pl_valid, 0);
    pl_rd = 1'b1;
    @(negedge clk);
    pl_rd = 1'b0;
    chk(buf_count == PW'(occ), "R8 read without valid ignored", buf_count, occ);
    desc_pop = 1'b1;
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      logic [DW-1:0] e;
      e = exp_words.pop_front();
      chk(pl_valid == 1'b1, "R8 payload valid during frame", pl_valid, 1);
      chk(pl_data == e, "R2 payload word order", pl_data, e);
      chk(desc_valid == 1'b0, "R8 descriptor hidden during frame", desc_valid, 0);
      desc_pop = (i == 0);
      pl_rd = 1'b1;
      @(negedge clk);
    end
    desc_pop = 1'b0;
    pl_rd = 1'b0;
    occ -= n;
    mdesc--;
    chk(pl_valid == 1'b0, "R8 payload ends after count", pl_valid, 0);
    chk(buf_count == PW'(occ), "R8 count after drain", buf_count, occ);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0;
    in_valid = 0; in_end = 0; in_good = 0; in_data = '0; in_src = '0;
    desc_pop = 0; pl_rd = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(buf_empty == 1'b1, "R1 empty", buf_empty, 1);
    chk(buf_count == '0, "R1 count", buf_count, 0);
    chk(desc_valid == 1'b0, "R1 desc_valid", desc_valid, 0);
    chk(pl_valid == 1'b0, "R1 pl_valid", pl_valid, 0);
    chk(ovf_count == '0, "R1 ovf_count", ovf_count, 0);

    // R5: strobe with last word, then strobe in its own cycle
    send_frame(3, 1, 1, 48'h0A0B_0C0D_0E01);
    send_frame(3, 1, 0, 48'h0A0B_0C0D_0E02);
    drain_one();
    drain_one();
    // R9: empty good frame
    send_frame(0, 1, 0, 48'h1111_2222_3333);
    // R3: bad frame between good ones
    send_frame(5, 1, 1, 48'h0000_0000_00AA);
    send_frame(7, 0, 1, 48'h0000_0000_00BB);
    send_frame(2, 1, 0, 48'h0000_0000_00CC);
    drain_one();
    drain_one();
    // R6: exact fill kept, one more dropped
    send_frame(DEPTH, 1, 1, 48'hFEED_0000_0040);
    chk(buf_empty == 1'b0, "R6 full buffer not empty", buf_empty, 0);
    drain_one();
    send_frame(DEPTH + 1, 1, 1, 48'hFEED_0000_0041);
    send_frame(4, 1, 1, 48'hFEED_0000_0001);
    send_frame(DEPTH, 0, 0, 48'hFEED_0000_0042);
    drain_one();
    // R7: descriptor queue full
    for (int i = 0; i < DESC_DEPTH; i++) send_frame(1, 1, 1, 48'(i + 100));
    send_frame(2, 1, 1, 48'hDEAD_0000_0007);
    while (mdesc > 0) drain_one();

    for (int f = 0; f < 250; f++) begin
      int n;
      n = ($urandom_range(0, 9) == 0) ? $urandom_range(30, 70) : $urandom_range(0, 20);
      send_frame(n, $urandom_range(0, 3) != 0, $urandom_range(0, 1), {$urandom, 16'(f)});
      if (mdesc > 0 && $urandom_range(0, 2) == 0) drain_one();
    end
    while (mdesc > 0) drain_one();
    chk(buf_empty == 1'b1, "R2 empty after full drain", buf_empty, 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule